// File: doc/BRIEF.md
# Dual Microsecond Tick Timer

This block provides two independent 32-bit up-counting timers driven by one shared 8-bit prescaler. The prescaler counts bus clocks and reloads from a software-written adjust byte. When that byte is 256 minus the bus clock frequency in MHz, the prescaler emits one tick per microsecond. Every timer counter advances on that tick, so a compare value written in microseconds is the timer period with no further scaling.

Each timer has a compare register, a counter register and a control byte. The control byte holds an enable bit, a restart-on-match bit and a write-only clear for a 4-bit match tally, which reads back in the top nibble. A match between the incremented count and the compare value drives a one-cycle request on that timer's `irq` bit. Software reaches every register through a single-cycle write strobe with a combinational read port. Long-word registers take all 32 data bits. Byte registers take the low 8 bits and read back zero-extended.

Top module: `tt_tick_pair`

## Requirements
- R1: After a clock edge with `rst_n` low, all compare and counter registers read 0, both control bytes read 0x00, the adjust byte and the live prescaler both read 256 - CLK_MHZ, and `irq` is 0.
- R2: While the prescaler is below 255 it rises by one each clock. In a cycle where it shows 255, a tick occurs, and on the next edge it loads the adjust byte, so a tick occurs every 256 - adjust clocks. Address 0x10 reads the live prescaler value. Writes to 0x10 are ignored.
- R3: The adjust byte at 0x11 can be read and written. A new value takes effect at the next reload, and a reload in the same cycle as the write uses the old value.
- R4: A timer counter changes only on a tick with its enable bit (control bit 0) set, or when software writes it.
- R5: With restart-on-match (control bit 1) set, a tick whose incremented count equals the compare value loads the counter with 0.
- R6: With restart-on-match clear, the counter passes the compare value and wraps from 0xFFFFFFFF to 0.
- R7: A match sets that timer's `irq` bit for exactly the one cycle after the tick cycle, whatever the restart-on-match setting. A software write to the counter in the tick cycle suppresses the match.
- R8: Each match adds one to the timer's 4-bit match tally, which wraps from 15 to 0 and reads as control bits [7:4].
- R9: Writing a control byte with bit 2 set clears the tally, and this takes priority over a match in the same cycle. Control bits 2 and 3 read as 0.
- R10: Long-word map: 0x00 is the timer 0 compare, 0x04 the timer 0 counter, 0x08 the timer 1 compare and 0x0C the timer 1 counter. A counter write takes priority over a tick in the same cycle.
- R11: Byte map: 0x12 is the timer 0 control and 0x13 the timer 1 control. Byte writes use `reg_wdata[7:0]`. Any other address reads 0, and writes to it change nothing.
- R12: A write to one timer's registers leaves the other timer's count, compare, control and tally unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Register byte address, used for both reads and writes |
| reg_wdata | input | 32 | Write data; byte registers use bits [7:0] |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 2 | Per-timer one-cycle match request, bit i for timer i |

## Verification
A written register reads back in the cycle after the write strobe, because the read path is combinational from the register outputs. A tick seen in cycle t updates the counter, the tally and `irq` at the edge that ends cycle t, so the bench checks these values in cycle t+1. The prescaler shows the adjust value in the cycle after it showed 255. The bench runs a behavioural model that is updated at each rising edge from the same inputs the design sees. It compares `irq` and `reg_rdata` in the middle of every low clock phase, after the read address has settled. Directed reads with values worked out by hand add checks of wrap-around, write precedence and tally clearing at known cycle counts.

// File: rtl/tt_pkg.sv
// Package: shared constants for the dual tick timer.
// Assumes a 5-bit byte address space and exactly two timers.
package tt_pkg;

    localparam int NUM_TIMERS = 2;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 32;
    localparam int PRESC_W    = 8;
    localparam int TALLY_W    = 4;
    localparam int CTRL_W     = TALLY_W + 4;

    // Long-word map: timer i compare at i*LONG_STRIDE, counter 4 bytes above
    localparam int LONG_STRIDE = 8;
    localparam int CNT_OFFSET  = 4;

    // Byte map
    localparam logic [ADDR_W-1:0] A_PRESC     = 5'h10;
    localparam logic [ADDR_W-1:0] A_ADJ       = 5'h11;
    localparam logic [ADDR_W-1:0] A_CTRL_BASE = 5'h12;

    // Control byte bit positions
    localparam int BIT_EN  = 0;
    localparam int BIT_RST = 1;
    localparam int BIT_CLR = 2;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_CMP,
        RD_CNT,
        RD_PRESC,
        RD_ADJ,
        RD_CTRL
    } rd_kind_e;

endpackage

// File: rtl/tt_prescaler.sv
// Module: tt_prescaler
// Shared prescaler. It counts up once per clock. In the cycle where it shows
// all ones it raises tick, and at the following edge it reloads from the
// adjust register. Assumes adjust writes arrive as single-cycle strobes.
module tt_prescaler #(
    parameter int                 W       = 8,
    parameter logic [W-1:0]       ADJ_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adj_wr,
    input  logic [W-1:0] adj_wdata,
    output logic [W-1:0] presc_q,
    output logic [W-1:0] adj_q,
    output logic         tick
);

    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = W'(1);

    // Tick whenever the prescaler sits at its top value
    assign tick = (presc_q == ALL_ONES);

    // Count up, reloading from the adjust byte after the top value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= ADJ_RST;
        end else if (tick) begin
            presc_q <= adj_q;
        end else begin
            presc_q <= presc_q + ONE;
        end
    end

    // Hold the software-written adjust byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q <= ADJ_RST;
        end else if (adj_wr) begin
            adj_q <= adj_wdata;
        end
    end

endmodule

// File: rtl/tt_timer.sv
// Module: tt_timer
// One compare timer. On a tick with enable set, the count advances. If the
// incremented value equals the compare, a match fires: irq pulses for one
// cycle, the tally increments, and with restart set the count returns to 0.
// A software counter write overrides the tick and suppresses the match.
// A control write with the clear bit set zeroes the tally and overrides a match.
module tt_timer #(
    parameter int CW = 32,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cmp_wr,
    input  logic          cnt_wr,
    input  logic          ctrl_wr,
    input  logic [CW-1:0] wdata,
    input  logic [2:0]    ctrl_wdata,
    output logic [CW-1:0] cmp_q,
    output logic [CW-1:0] cnt_q,
    output logic [OW+3:0] ctrl_rd,
    output logic [OW-1:0] ovf_q,
    output logic          irq
);

    import tt_pkg::*;

    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [OW-1:0] OVF_ONE = OW'(1);

    logic          en_q;
    logic          rst_on_hit_q;
    logic [CW-1:0] cnt_nxt;
    logic          hit;

    // Incremented count and the match it produces on this tick
    assign cnt_nxt = cnt_q + CNT_ONE;
    assign hit     = tick && en_q && (cnt_nxt == cmp_q) && !cnt_wr;

    // Counter: a software write wins, otherwise advance on enabled ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (tick && en_q) begin
            cnt_q <= (hit && rst_on_hit_q) ? '0 : cnt_nxt;
        end
    end

    // Compare register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= wdata;
        end
    end

    // Control bits: enable and restart-on-match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q         <= 1'b0;
            rst_on_hit_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q         <= ctrl_wdata[BIT_EN];
            rst_on_hit_q <= ctrl_wdata[BIT_RST];
        end
    end

    // Match tally: clear has priority over a same-cycle match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else if (ctrl_wr && ctrl_wdata[BIT_CLR]) begin
            ovf_q <= '0;
        end else if (hit) begin
            ovf_q <= ovf_q + OVF_ONE;
        end
    end

    // One-cycle match request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= hit;
        end
    end

    // Control byte as read by software
    assign ctrl_rd = {ovf_q, 2'b00, rst_on_hit_q, en_q};

endmodule

// File: rtl/tt_decode.sv
// Module: tt_decode
// Address decoder. It turns the byte address and write strobe into one write
// strobe per register and a read selector. Assumes the map in tt_pkg.
module tt_decode
    import tt_pkg::*;
(
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_TIMERS-1:0] cmp_wr,
    output logic [NUM_TIMERS-1:0] cnt_wr,
    output logic [NUM_TIMERS-1:0] ctrl_wr,
    output logic                  adj_wr,
    output rd_kind_e              rd_kind,
    output logic                  rd_idx
);

    // Per-timer write strobes
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_wr
        assign cmp_wr[i]  = wr && (addr == ADDR_W'(i * LONG_STRIDE));
        assign cnt_wr[i]  = wr && (addr == ADDR_W'(i * LONG_STRIDE + CNT_OFFSET));
        assign ctrl_wr[i] = wr && (addr == A_CTRL_BASE + ADDR_W'(i));
    end

    assign adj_wr = wr && (addr == A_ADJ);

    // Read selector for the top-level mux
    always_comb begin
        rd_kind = RD_NONE;
        rd_idx  = 1'b0;
        if (addr == A_PRESC) rd_kind = RD_PRESC;
        if (addr == A_ADJ)   rd_kind = RD_ADJ;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (addr == ADDR_W'(i * LONG_STRIDE)) begin
                rd_kind = RD_CMP;
                rd_idx  = 1'(i);
            end
            if (addr == ADDR_W'(i * LONG_STRIDE + CNT_OFFSET)) begin
                rd_kind = RD_CNT;
                rd_idx  = 1'(i);
            end
            if (addr == A_CTRL_BASE + ADDR_W'(i)) begin
                rd_kind = RD_CTRL;
                rd_idx  = 1'(i);
            end
        end
    end

endmodule

// File: rtl/tt_tick_pair.sv
// Module: tt_tick_pair (top)
// Two compare timers sharing one prescaler, behind a byte/long register port.
// Assumes CLK_MHZ is between 1 and 255. The adjust byte resets to
// 256 - CLK_MHZ so that the default tick period is one microsecond.
module tt_tick_pair #(
    parameter int CLK_MHZ = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [1:0]  irq
);

    import tt_pkg::*;

    localparam logic [PRESC_W-1:0] ADJ_RST = PRESC_W'(256 - CLK_MHZ);

    logic                                tick;
    logic [PRESC_W-1:0]                  presc_q;
    logic [PRESC_W-1:0]                  adj_q;
    logic                                adj_wr;
    logic [NUM_TIMERS-1:0]               cmp_wr;
    logic [NUM_TIMERS-1:0]               cnt_wr;
    logic [NUM_TIMERS-1:0]               ctrl_wr;
    logic [NUM_TIMERS-1:0][DATA_W-1:0]   cmp_q;
    logic [NUM_TIMERS-1:0][DATA_W-1:0]   cnt_q;
    logic [NUM_TIMERS-1:0][CTRL_W-1:0]   ctrl_rd;
    logic [NUM_TIMERS-1:0][TALLY_W-1:0]  ovf_q;
    rd_kind_e                            rd_kind;
    logic                                rd_idx;

    tt_decode u_decode (
        .wr      (reg_wr),
        .addr    (reg_addr),
        .cmp_wr  (cmp_wr),
        .cnt_wr  (cnt_wr),
        .ctrl_wr (ctrl_wr),
        .adj_wr  (adj_wr),
        .rd_kind (rd_kind),
        .rd_idx  (rd_idx)
    );

    tt_prescaler #(
        .W       (PRESC_W),
        .ADJ_RST (ADJ_RST)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adj_wr    (adj_wr),
        .adj_wdata (reg_wdata[PRESC_W-1:0]),
        .presc_q   (presc_q),
        .adj_q     (adj_q),
        .tick      (tick)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        tt_timer #(
            .CW (DATA_W),
            .OW (TALLY_W)
        ) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .cmp_wr     (cmp_wr[i]),
            .cnt_wr     (cnt_wr[i]),
            .ctrl_wr    (ctrl_wr[i]),
            .wdata      (reg_wdata),
            .ctrl_wdata (reg_wdata[2:0]),
            .cmp_q      (cmp_q[i]),
            .cnt_q      (cnt_q[i]),
            .ctrl_rd    (ctrl_rd[i]),
            .ovf_q      (ovf_q[i]),
            .irq        (irq[i])
        );
    end

    // Read mux: long registers full width, byte registers zero-extended
    always_comb begin
        unique case (rd_kind)
            RD_CMP:   reg_rdata = cmp_q[rd_idx];
            RD_CNT:   reg_rdata = cnt_q[rd_idx];
            RD_PRESC: reg_rdata = DATA_W'(presc_q);
            RD_ADJ:   reg_rdata = DATA_W'(adj_q);
            RD_CTRL:  reg_rdata = DATA_W'(ctrl_rd[rd_idx]);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tt_tick_pair_chk.sv
// Module: tt_tick_pair_chk
// Property checker for tt_tick_pair, attached with bind below.
// It observes the prescaler, the per-timer counts, tallies and strobes.
module tt_tick_pair_chk (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [7:0]       presc,
    input  logic [7:0]       adj,
    input  logic [1:0]       irq,
    input  logic [1:0][31:0] cnt,
    input  logic [1:0][3:0]  ovf,
    input  logic [1:0]       cnt_wr,
    input  logic [1:0]       ctrl_wr
);

    logic past_ok;

    // Marks that the previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: after a tick the prescaler holds the adjust value of that cycle
    assert_presc_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tick) |-> presc == $past(adj));

    // R2: without a tick the prescaler steps by one
    assert_presc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(tick) |-> presc == $past(presc) + 8'd1);

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R7: a request only follows a tick cycle
        assert_irq_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> past_ok && $past(tick));

        // R4: the count holds without a tick or a write
        assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && !$past(tick) && !$past(cnt_wr[i]) |-> $stable(cnt[i]));

        // R8: the tally moves only with a request or a control write
        assert_tally_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && !$past(ctrl_wr[i]) && !$stable(ovf[i]) |-> irq[i]);

        // R8: each request adds exactly one to the tally
        assert_tally_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && irq[i] && !$past(ctrl_wr[i]) |-> ovf[i] == $past(ovf[i]) + 4'd1);
    end

endmodule

bind tt_tick_pair tt_tick_pair_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .presc   (presc_q),
    .adj     (adj_q),
    .irq     (irq),
    .cnt     (cnt_q),
    .ovf     (ovf_q),
    .cnt_wr  (cnt_wr),
    .ctrl_wr (ctrl_wr)
);

// File: tb/tt_tick_pair_test.sv
// Bench for tt_tick_pair: a behavioural model is stepped at every rising
// edge and compared with the outputs in every low phase. Directed reads
// add checks against values worked out by hand.
module tt_tick_pair_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails = 0;
    bit started = 0;
    bit done = 0;

    // Model state
    int unsigned m_presc, m_adj, m_nx;
    int unsigned m_cnt [2];
    int unsigned m_cmp [2];
    int unsigned m_ovf [2];
    bit          m_en  [2];
    bit          m_rst [2];
    bit          m_irq [2];
    bit          m_tk;

    tt_tick_pair #(.CLK_MHZ(50)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int unsigned m_ctrl(input int i);
        return (m_ovf[i] << 4) | (int'(m_rst[i]) << 1) | int'(m_en[i]);
    endfunction

    function automatic int unsigned m_read(input int a);
        case (a)
            0:  return m_cmp[0];
            4:  return m_cnt[0];
            8:  return m_cmp[1];
            12: return m_cnt[1];
            16: return m_presc;
            17: return m_adj;
            18: return m_ctrl(0);
            19: return m_ctrl(1);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(input int a);
        case (a)
            0, 4, 8, 12: return "R10";
            16:          return "R2";
            17:          return "R3";
            18, 19:      return "R8";
            default:     return "R11";
        endcase
    endfunction

    // Model: advance one clock from the inputs seen at this edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_presc = 206; m_adj = 206;
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_cmp[i] = 0; m_ovf[i] = 0;
                m_en[i] = 0; m_rst[i] = 0; m_irq[i] = 0;
            end
        end else begin
            m_tk = (m_presc == 255);
            for (int i = 0; i < 2; i++) begin
                m_irq[i] = 0;
                if (reg_wr && reg_addr == 5'(8 * i + 4)) begin
                    m_cnt[i] = reg_wdata;
                end else if (m_tk && m_en[i]) begin
                    m_nx = m_cnt[i] + 1;
                    if (m_nx == m_cmp[i]) begin
                        m_irq[i] = 1;
                        m_ovf[i] = (m_ovf[i] + 1) % 16;
                        m_cnt[i] = m_rst[i] ? 0 : m_nx;
                    end else begin
                        m_cnt[i] = m_nx;
                    end
                end
                if (reg_wr && reg_addr == 5'(8 * i)) m_cmp[i] = reg_wdata;
                if (reg_wr && reg_addr == 5'(18 + i)) begin
                    m_en[i]  = reg_wdata[0];
                    m_rst[i] = reg_wdata[1];
                    if (reg_wdata[2]) m_ovf[i] = 0;
                end
            end
            m_presc = m_tk ? m_adj : m_presc + 1;
            if (reg_wr && reg_addr == 5'h11) m_adj = reg_wdata[7:0];
        end
        started = 1;
    end

    // Compare outputs with the model in every low phase
    always @(negedge clk) begin
        #2;
        if (started && !done) begin
            check(irq == {m_irq[1], m_irq[0]}, "R7", 32'(irq), {30'b0, m_irq[1], m_irq[0]});
            check(reg_rdata == m_read(int'(reg_addr)), tag_for(int'(reg_addr)),
                  reg_rdata, m_read(int'(reg_addr)));
        end
    end

    task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1: actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d, d2;
        idle(3);
        rst_n = 1'b1;

        // R1: reset values
        read_reg(5'h11, d); check(d == 32'd206, "R1", d, 32'd206);
        read_reg(5'h04, d); check(d == 32'd0, "R1", d, 32'd0);
        read_reg(5'h13, d); check(d == 32'd0, "R1", d, 32'd0);
        check(irq == 2'b00, "R1", 32'(irq), 32'd0);
        idle(120);

        // R3: shorter prescaler period
        write_reg(5'h11, 32'hFFFF_FFFA);
        read_reg(5'h11, d); check(d == 32'd250, "R3", d, 32'd250);

        // R5: timer 0 restarts at compare 5
        write_reg(5'h00, 32'd5);
        write_reg(5'h12, 32'h03);
        for (int k = 0; k < 60; k++) begin
            read_reg(5'h04, d);
            check(d < 32'd5, "R5", d, 32'd4);
        end

        // R8: tick every clock, match every tick, tally wraps
        write_reg(5'h11, 32'd255);
        idle(10);
        write_reg(5'h00, 32'd1);
        write_reg(5'h04, 32'd0);
        read_reg(5'h12, d);
        idle(40);
        write_reg(5'h12, 32'h00);
        read_reg(5'h12, d);

        // R6: timer 1 passes its compare and wraps
        write_reg(5'h08, 32'd2);
        write_reg(5'h0C, 32'hFFFF_FFFE);
        write_reg(5'h13, 32'h01);
        idle(4);
        read_reg(5'h0C, d); check(d == 32'd3, "R6", d, 32'd3);
        read_reg(5'h13, d); check(d == 32'h11, "R8", d, 32'h11);

        // R10: a counter write wins over the same-cycle tick
        write_reg(5'h0C, 32'h100);
        read_reg(5'h0C, d); check(d == 32'h101, "R10", d, 32'h101);

        // R9: clear the timer 0 tally, control bits 2 and 3 read 0
        write_reg(5'h12, 32'h0C);
        read_reg(5'h12, d); check(d == 32'h00, "R9", d, 32'h00);

        // R12: timer 1 is unaffected by the timer 0 writes
        read_reg(5'h13, d); check(d == 32'h11, "R12", d, 32'h11);

        // R4: a disabled counter holds
        read_reg(5'h04, d);
        idle(20);
        read_reg(5'h04, d2); check(d2 == d, "R4", d2, d);

        // R11: unmapped addresses
        write_reg(5'h01, 32'hFFFF_FFFF);
        write_reg(5'h14, 32'hFFFF_FFFF);
        write_reg(5'h1F, 32'hFFFF_FFFF);
        read_reg(5'h01, d); check(d == 32'd0, "R11", d, 32'd0);
        read_reg(5'h14, d); check(d == 32'd0, "R11", d, 32'd0);
        read_reg(5'h1F, d); check(d == 32'd0, "R11", d, 32'd0);

        // R2: a write to the live prescaler is ignored
        write_reg(5'h10, 32'h00);
        read_reg(5'h10, d); check(d == 32'd255, "R2", d, 32'd255);

        // R7: timer 0 without restart, default period again
        write_reg(5'h11, 32'd206);
        write_reg(5'h00, 32'd3);
        write_reg(5'h04, 32'd0);
        write_reg(5'h12, 32'h01);
        read_reg(5'h12, d);
        idle(400);

        finish_run();
    end

endmodule